// File: doc/BRIEF.md
# Read-Priority Write Buffer

This block sits between a cache and the next memory level and holds outgoing writes. Each write is an address and a data word. The cache hands over stores or evicted dirty lines and carries on without waiting for memory to complete them. Queued writes leave for memory in the order they arrived. They use a single request port with a valid/ready handshake and a read/write flag.

A read miss from the cache must not bypass a newer value that is still queued. When a miss is accepted, the block compares its address in parallel with every occupied entry, and also with a write accepted in the same cycle. On a match the newest value is returned directly and memory is not read. With no match, the read is sent to memory ahead of all queued writes. The word that memory returns is passed on to the cache. Only one read miss is outstanding at a time.

The memory side samples a request only in the cycle its handshake completes. The request on offer may therefore change from a write to a read while ready is low. Memory answers a read no earlier than one cycle after accepting it.

Top module: `read_priority_wbuf`

## Requirements
- R1: Accepted writes (wr_valid and wr_ready both high) leave on the memory port as write requests (mem_req_write = 1), carrying the same address and data, in the order they were accepted. Once mem_req_valid is raised, it stays high until a handshake completes.
- R2: wr_ready is low exactly when all DEPTH entries (4 by default) are occupied.
- R3: A read whose address equals a buffered entry's address is a hit. rd_resp_valid is high for one cycle, in the cycle after acceptance. rd_resp_data is the data of the most recently accepted matching write. No memory read is issued for a hit.
- R4: A read that matches nothing is presented to memory as a read request (mem_req_write = 0) with its address from the cycle after acceptance. No queued write is accepted by memory until the read has been accepted.
- R5: The data of a mem_resp_valid pulse for the outstanding read appears on rd_resp_data with rd_resp_valid high in the following cycle.
- R6: rd_req_ready is low from the cycle after a miss is accepted until the cycle after its memory response arrives. At all other times it is high.
- R7: A write and a read to the same address accepted in the same cycle count as a hit. The read returns the new write's data.
- R8: After reset the buffer is empty: wr_ready = 1, rd_req_ready = 1, mem_req_valid = 0 and rd_resp_valid = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Cache offers a write |
| wr_ready | output | 1 | Buffer can take a write |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rd_req_valid | input | 1 | Cache offers a read miss |
| rd_req_ready | output | 1 | Buffer can take a read miss |
| rd_req_addr | input | ADDR_W | Read miss address |
| rd_resp_valid | output | 1 | One-cycle read data pulse |
| rd_resp_data | output | DATA_W | Read data to cache |
| mem_req_valid | output | 1 | Request offered to memory |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | ADDR_W | Request address |
| mem_req_wdata | output | DATA_W | Write data to memory |
| mem_resp_valid | input | 1 | Memory read data valid |
| mem_resp_data | input | DATA_W | Memory read data |

## Verification
Two pairs of events can land in the same clock edge. A cache write can be accepted in the cycle a read miss to the same address is accepted. The oldest entry can drain to memory while a new miss searches for it. The bench provokes the first pair in a directed step and both pairs repeatedly in a random phase. That phase uses only eight addresses, so matches are frequent. It judges each read against a shadow of the last value written per address and against a queue model that decides hit or miss. A miss that arrives while memory holds ready low tests priority: the next memory handshake must be the read, not a queued write.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  typedef enum logic [1:0] {
    RD_IDLE  = 2'd0,
    RD_ISSUE = 2'd1,
    RD_WAIT  = 2'd2
  } rd_state_e;
endpackage

// File: rtl/wbuf_store.sv
module wbuf_store #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  input  logic [ADDR_W-1:0] look_addr,
  output logic [PTR_W:0]    count,
  output logic [ADDR_W-1:0] head_addr,
  output logic [DATA_W-1:0] head_data,
  output logic              look_hit,
  output logic [DATA_W-1:0] look_data
);
  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [DEPTH-1:0]  vld_q;
  logic [DEPTH-1:0]  match;
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;

  // payload storage carries no reset
  always_ff @(posedge clk) begin
    if (push) begin
      addr_q[wr_ptr] <= push_addr;
      data_q[wr_ptr] <= push_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= '0;
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (pop) begin
        vld_q[rd_ptr] <= 1'b0;
        rd_ptr        <= rd_ptr + 1'b1;
      end
      if (push) begin
        vld_q[wr_ptr] <= 1'b1;
        wr_ptr        <= wr_ptr + 1'b1;
      end
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // one comparator per entry
  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign match[i] = vld_q[i] && (addr_q[i] == look_addr);
  end

  // walk from oldest to newest; the last match wins
  always_comb begin
    look_hit  = 1'b0;
    look_data = '0;
    for (int k = 0; k < DEPTH; k++) begin
      logic [PTR_W-1:0] idx;
      idx = rd_ptr + PTR_W'(k);
      if (match[idx]) begin
        look_hit  = 1'b1;
        look_data = data_q[idx];
      end
    end
  end

  assign head_addr = addr_q[rd_ptr];
  assign head_data = data_q[rd_ptr];
endmodule

// File: rtl/wbuf_arbiter.sv
module wbuf_arbiter
  import wbuf_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_req_valid,
  input  logic [ADDR_W-1:0] rd_req_addr,
  input  logic              hit,
  input  logic [DATA_W-1:0] hit_data,
  input  logic              q_nonempty,
  input  logic [ADDR_W-1:0] head_addr,
  input  logic [DATA_W-1:0] head_data,
  input  logic              mem_req_ready,
  input  logic              mem_resp_valid,
  input  logic [DATA_W-1:0] mem_resp_data,
  output logic              rd_req_ready,
  output logic              rd_fire,
  output logic              rd_resp_valid,
  output logic [DATA_W-1:0] rd_resp_data,
  output logic              mem_req_valid,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  output logic              pop,
  output logic              rd_issue,
  output logic              rd_wait
);
  rd_state_e         state;
  logic [ADDR_W-1:0] miss_addr;

  assign rd_issue     = (state == RD_ISSUE);
  assign rd_wait      = (state == RD_WAIT);
  assign rd_req_ready = (state == RD_IDLE);
  assign rd_fire      = rd_req_valid && rd_req_ready;

  // a waiting read takes the port ahead of every queued write
  assign mem_req_valid = rd_issue || q_nonempty;
  assign mem_req_write = !rd_issue;
  assign mem_req_addr  = rd_issue ? miss_addr : head_addr;
  assign mem_req_wdata = head_data;
  assign pop           = !rd_issue && q_nonempty && mem_req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= RD_IDLE;
      miss_addr     <= '0;
      rd_resp_valid <= 1'b0;
      rd_resp_data  <= '0;
    end else begin
      rd_resp_valid <= 1'b0;
      case (state)
        RD_IDLE: begin
          if (rd_fire) begin
            if (hit) begin
              rd_resp_valid <= 1'b1;
              rd_resp_data  <= hit_data;
            end else begin
              state     <= RD_ISSUE;
              miss_addr <= rd_req_addr;
            end
          end
        end
        RD_ISSUE: if (mem_req_ready) state <= RD_WAIT;
        RD_WAIT: begin
          if (mem_resp_valid) begin
            state         <= RD_IDLE;
            rd_resp_valid <= 1'b1;
            rd_resp_data  <= mem_resp_data;
          end
        end
        default: state <= RD_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/read_priority_wbuf.sv
module read_priority_wbuf #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_req_valid,
  output logic              rd_req_ready,
  input  logic [ADDR_W-1:0] rd_req_addr,
  output logic              rd_resp_valid,
  output logic [DATA_W-1:0] rd_resp_data,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_resp_valid,
  input  logic [DATA_W-1:0] mem_resp_data
);
  logic [PTR_W:0]    fifo_count;
  logic [ADDR_W-1:0] head_addr;
  logic [DATA_W-1:0] head_data;
  logic              store_hit;
  logic [DATA_W-1:0] store_data;
  logic              look_hit;
  logic [DATA_W-1:0] look_data;
  logic              wr_fire, fwd_hit, pop, rd_fire, rd_issue, rd_wait;

  assign wr_ready = (fifo_count != (PTR_W+1)'(DEPTH));
  assign wr_fire  = wr_valid && wr_ready;

  // a write entering this cycle counts as the newest entry
  assign fwd_hit   = wr_fire && (wr_addr == rd_req_addr);
  assign look_hit  = fwd_hit || store_hit;
  assign look_data = fwd_hit ? wr_data : store_data;

  wbuf_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .rst       (rst),
    .push      (wr_fire),
    .push_addr (wr_addr),
    .push_data (wr_data),
    .pop       (pop),
    .look_addr (rd_req_addr),
    .count     (fifo_count),
    .head_addr (head_addr),
    .head_data (head_data),
    .look_hit  (store_hit),
    .look_data (store_data)
  );

  wbuf_arbiter #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arb (
    .clk            (clk),
    .rst            (rst),
    .rd_req_valid   (rd_req_valid),
    .rd_req_addr    (rd_req_addr),
    .hit            (look_hit),
    .hit_data       (look_data),
    .q_nonempty     (fifo_count != '0),
    .head_addr      (head_addr),
    .head_data      (head_data),
    .mem_req_ready  (mem_req_ready),
    .mem_resp_valid (mem_resp_valid),
    .mem_resp_data  (mem_resp_data),
    .rd_req_ready   (rd_req_ready),
    .rd_fire        (rd_fire),
    .rd_resp_valid  (rd_resp_valid),
    .rd_resp_data   (rd_resp_data),
    .mem_req_valid  (mem_req_valid),
    .mem_req_write  (mem_req_write),
    .mem_req_addr   (mem_req_addr),
    .mem_req_wdata  (mem_req_wdata),
    .pop            (pop),
    .rd_issue       (rd_issue),
    .rd_wait        (rd_wait)
  );
endmodule

// File: rtl/wbuf_checker.sv
module wbuf_checker #(
  parameter int DEPTH = 4,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input logic           clk,
  input logic           rst,
  input logic           wr_ready,
  input logic           rd_req_ready,
  input logic           rd_resp_valid,
  input logic           mem_req_valid,
  input logic           mem_req_ready,
  input logic           mem_req_write,
  input logic           mem_resp_valid,
  input logic [PTR_W:0] fifo_count,
  input logic           rd_fire,
  input logic           look_hit,
  input logic           rd_issue,
  input logic           rd_wait
);
  p_req_held_r1: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> mem_req_valid);

  p_full_stall_r2: assert property (@(posedge clk) disable iff (rst)
    (fifo_count == (PTR_W+1)'(DEPTH)) |-> !wr_ready);

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst)
    fifo_count <= (PTR_W+1)'(DEPTH));

  p_hit_local_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_fire && look_hit) |=> (rd_resp_valid && !rd_issue && !rd_wait));

  p_read_first_r4: assert property (@(posedge clk) disable iff (rst)
    rd_issue |-> (mem_req_valid && !mem_req_write));

  p_miss_issue_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_fire && !look_hit) |=> (rd_issue && !rd_resp_valid));

  p_resp_forward_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_wait && mem_resp_valid) |=> (rd_resp_valid && rd_req_ready));

  p_single_read_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_issue || rd_wait) |-> !rd_req_ready);
endmodule

bind read_priority_wbuf wbuf_checker #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/read_priority_wbuf_test.sv
module read_priority_wbuf_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_valid = 1'b0, rd_req_valid = 1'b0, mem_req_ready = 1'b0, mem_resp_valid = 1'b0;
  logic [15:0] wr_addr = '0, rd_req_addr = '0;
  logic [31:0] wr_data = '0, mem_resp_data = '0;
  logic        wr_ready, rd_req_ready, rd_resp_valid, mem_req_valid, mem_req_write;
  logic [31:0] rd_resp_data, mem_req_wdata;
  logic [15:0] mem_req_addr;

  always #10 clk = ~clk;

  read_priority_wbuf uut (.*);

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // reference models
  logic [15:0] q_addr [16];
  logic [31:0] q_data [16];
  int          qh = 0, qn = 0;
  logic [31:0] shadow [16];
  logic [31:0] marr   [16];
  bit          miss_issue = 0, miss_out = 0, resp_due = 0;
  logic [15:0] miss_addr;
  logic [31:0] miss_exp, resp_exp, resp_val;
  string       resp_tag;
  int          lat = 0;

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(bit wv, logic [15:0] wa, logic [31:0] wd,
                      bit rv, logic [15:0] ra, bit mr);
    bit wf, rf, in_q, in_store;
    @(negedge clk);
    // registered results of the previous edge
    chk(rd_resp_valid == resp_due, resp_tag, 64'(rd_resp_valid), 64'(resp_due));
    if (resp_due) chk(rd_resp_data == resp_exp, resp_tag, 64'(rd_resp_data), 64'(resp_exp));
    resp_due = 0;
    chk(wr_ready == (qn < 4), "R2 wr_ready", 64'(wr_ready), 64'(qn < 4));
    chk(rd_req_ready == !miss_out, "R6 rd_req_ready", 64'(rd_req_ready), 64'(!miss_out));
    // drive inputs
    mem_resp_valid = 1'b0;
    if (lat > 0) begin
      lat--;
      if (lat == 0) begin
        mem_resp_valid = 1'b1;
        mem_resp_data  = resp_val;
        resp_due = 1; resp_exp = miss_exp; resp_tag = "R5 miss data";
        miss_out = 0;
      end
    end
    wr_valid = wv; wr_addr = wa; wr_data = wd;
    rd_req_valid = rv; rd_req_addr = ra; mem_req_ready = mr;
    #1;
    wf = wr_valid && wr_ready;
    rf = rd_req_valid && rd_req_ready;
    // hazard decision against the queue before this edge's drain
    in_store = 0;
    for (int k = 0; k < qn; k++) if (q_addr[(qh + k) % 16] == ra) in_store = 1;
    in_q = in_store || (wf && wa == ra);
    if (mem_req_valid && mem_req_ready) begin
      if (mem_req_write) begin
        chk(!miss_issue, "R4 write overtook read", 64'(mem_req_write), 64'(0));
        chk(qn > 0 && mem_req_addr == q_addr[qh] && mem_req_wdata == q_data[qh],
            "R1 drain order", {mem_req_addr, mem_req_wdata}, {q_addr[qh], q_data[qh]});
        marr[mem_req_addr[3:0]] = mem_req_wdata;
        qh = (qh + 1) % 16; qn--;
      end else begin
        chk(miss_issue, "R3 memory read without miss", 64'(miss_issue), 64'(1));
        chk(mem_req_addr == miss_addr, "R4 read addr", 64'(mem_req_addr), 64'(miss_addr));
        resp_val = marr[mem_req_addr[3:0]];
        lat = 1 + int'($urandom % 3);
        miss_issue = 0;
      end
    end
    if (wf) begin
      shadow[wa[3:0]] = wd;
      q_addr[(qh + qn) % 16] = wa; q_data[(qh + qn) % 16] = wd; qn++;
    end
    if (rf) begin
      if (in_q) begin
        resp_due = 1; resp_exp = shadow[ra[3:0]];
        resp_tag = in_store ? "R3 hit data" : "R7 same-cycle hit";
      end else begin
        miss_issue = 1; miss_out = 1; miss_addr = ra; miss_exp = shadow[ra[3:0]];
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) begin shadow[i] = 32'hDEAD_0000 + i; marr[i] = 32'hDEAD_0000 + i; end
    resp_tag = "R8 idle";
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    #1;
    // R8 reset state
    chk(wr_ready == 1'b1, "R8 wr_ready", 64'(wr_ready), 64'(1));
    chk(rd_req_ready == 1'b1, "R8 rd_req_ready", 64'(rd_req_ready), 64'(1));
    chk(mem_req_valid == 1'b0, "R8 mem_req_valid", 64'(mem_req_valid), 64'(0));
    chk(rd_resp_valid == 1'b0, "R8 rd_resp_valid", 64'(rd_resp_valid), 64'(0));
    // R2: fill with memory stalled, then a fifth write is refused
    step(1, 16'd1, 32'h11, 0, 0, 0);
    step(1, 16'd2, 32'h22, 0, 0, 0);
    step(1, 16'd1, 32'h33, 0, 0, 0);
    step(1, 16'd3, 32'h44, 0, 0, 0);
    step(1, 16'd4, 32'h55, 0, 0, 0);
    // R3: two entries for address 1, newest (0x33) expected
    step(0, 0, 0, 1, 16'd1, 0);
    // R4: miss while four writes wait; read must win the port
    step(0, 0, 0, 1, 16'd7, 0);
    step(0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1);
    for (int i = 0; i < 12; i++) step(0, 0, 0, 0, 0, 1);
    // R7: write and read of the same address in one cycle
    step(1, 16'd6, 32'h66, 1, 16'd6, 0);
    step(0, 0, 0, 0, 0, 1);
    // random phase over a narrow address range
    for (int i = 0; i < 4000; i++)
      step($urandom % 2 == 0, 16'($urandom % 8), $urandom,
           $urandom % 5 < 2, 16'($urandom % 8), $urandom % 5 < 3);
    for (int i = 0; i < 20; i++) step(0, 0, 0, 0, 0, 1);
    chk(qn == 0 && mem_req_valid == 1'b0, "R1 drained", 64'(mem_req_valid), 64'(0));
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule